// File: doc/BRIEF.md
# DMA Control and Status Register Bank

This block is the host-visible control plane of a DMA engine that moves data between local memory and devices on an external parallel peripheral bus. The host reaches it through a plain word-addressed register port. The bank holds a 24-bit local-memory address and a 32-bit bus address. It has two length registers, one per transfer direction, and writing either of them launches a transfer. It also has a status register, plus two sets of bus timing values (latency, strobe pulse width, page size, release time), one set per bus address domain.

Toward the bus engine the bank drives a one-cycle start pulse, the transfer direction, both addresses, the length of the launched transfer, an abort pulse and all timing values. In return it takes done, error and I/O-busy indications. Length values follow the byte-count-minus-one convention. The status register reports state when read and takes commands when written. A completion interrupt is held in the status register and mirrored on an output pin.

Top module: `dma_csr_bank`

## Requirements
- R1: After synchronous reset every register is zero, `eng_start`, `eng_abort` and `irq` are low, and a read of any offset returns zero.
- R2: Offset 0x00 holds the local-memory address in bits 23:0, and bits 31:24 read as zero. Offset 0x04 holds all 32 bits of the bus address. Both values appear unchanged on `eng_mem_addr` and `eng_bus_addr`.
- R3: `reg_rdata` is registered: it shows the register selected by `reg_addr` in the previous cycle. Address bits 1:0 are ignored. Offsets from 0x34 upward read zero, writes to them change nothing, and unused bits of any register read zero.
- R4: When the bank is idle, a write to 0x08 or 0x0C stores the low 24 data bits in that length register. In the next cycle `eng_start` is high for exactly one cycle, `eng_dir` is 0 for offset 0x08 (local memory to bus) or 1 for offset 0x0C (bus to local memory), `eng_len` carries the stored value, and status bit 0 (DMA busy) is set.
- R5: A write to either length register while DMA busy is set has no effect: no start pulse, and the length register and `eng_len` keep their values.
- R6: `eng_done` clears DMA busy and sets status bit 3 (interrupt), which `irq` mirrors. The interrupt stays set until cleared. If done and a clear arrive in the same cycle, the interrupt ends up set.
- R7: A status write with bit 1 set clears the interrupt. A status write with bit 1 clear leaves it unchanged.
- R8: A status write with bit 0 set gives a one-cycle `eng_abort` pulse in the next cycle and clears DMA busy and the error bit.
- R9: Status bit 2 (error) sets on `eng_error` and holds until an abort. Status bit 1 shows `eng_io_busy` as sampled in the read cycle.
- R10: Domain 1 timing words sit at 0x14 (latency, 8 bits), 0x18 (pulse width, 8 bits), 0x1C (page size, 4 bits) and 0x20 (release, 2 bits). Domain 2 uses the same layout at 0x24 to 0x30. Each value reads back masked to its width and drives its own output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| eng_start | output | 1 | One-cycle transfer launch pulse |
| eng_dir | output | 1 | 0 local memory to bus, 1 bus to local memory |
| eng_mem_addr | output | 24 | Local-memory start address |
| eng_bus_addr | output | 32 | Bus start address |
| eng_len | output | 24 | Byte count minus one of the launched transfer |
| eng_abort | output | 1 | One-cycle engine abort pulse |
| eng_done | input | 1 | Transfer complete pulse from the engine |
| eng_error | input | 1 | Error pulse from the engine |
| eng_io_busy | input | 1 | Engine single-access bus activity |
| irq | output | 1 | Completion interrupt |
| d1_lat | output | 8 | Domain 1 latency |
| d1_pwd | output | 8 | Domain 1 strobe pulse width |
| d1_pgs | output | 4 | Domain 1 page size |
| d1_rls | output | 2 | Domain 1 release time |
| d2_lat | output | 8 | Domain 2 latency |
| d2_pwd | output | 8 | Domain 2 strobe pulse width |
| d2_pgs | output | 4 | Domain 2 page size |
| d2_rls | output | 2 | Domain 2 release time |

## Verification
Several rules are checked by the assertions on every cycle: the start pulse lasts a single cycle, a length write while busy never produces a start, done always leaves the interrupt set, the interrupt persists until an explicit clear, an abort write pulses the engine and drops busy, and the local address readback has a zero upper byte. Other behaviour can only be shown by the bench's scenarios. This covers the values that come back through readback, the direction and length reported for each launch, the sticky error and its removal by abort, I/O busy in the status word, and the timing registers masked per domain. The bench's random register traffic covers the decoding of every offset, including the undecoded ones.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  localparam int DATA_W  = 32;
  localparam int LAT_W   = 8;
  localparam int PWD_W   = 8;
  localparam int PGS_W   = 4;
  localparam int RLS_W   = 2;
  localparam int TFLD_W  = 8;   // widest timing field
  localparam int NDOM    = 2;

  // word indices (byte offset >> 2)
  localparam int WI_MEM  = 0;
  localparam int WI_BUS  = 1;
  localparam int WI_RLEN = 2;
  localparam int WI_WLEN = 3;
  localparam int WI_STAT = 4;
  localparam int WI_TIM  = 5;   // first timing word of domain 1
  localparam int TIM_STRIDE = 4;

  // status bits on read
  localparam int SB_BUSY = 0;
  localparam int SB_IO   = 1;
  localparam int SB_ERR  = 2;
  localparam int SB_IRQ  = 3;
  // status bits on write
  localparam int SC_ABORT = 0;
  localparam int SC_CLEAR = 1;
endpackage

// File: rtl/dmacsr_timing_set.sv
module dmacsr_timing_set
  import dmacsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [1:0]        rd_sel,
  input  logic [TFLD_W-1:0] wdata,
  output logic [LAT_W-1:0]  lat,
  output logic [PWD_W-1:0]  pwd,
  output logic [PGS_W-1:0]  pgs,
  output logic [RLS_W-1:0]  rls,
  output logic [DATA_W-1:0] rval
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat <= '0;
      pwd <= '0;
      pgs <= '0;
      rls <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    lat <= wdata[LAT_W-1:0];
        2'd1:    pwd <= wdata[PWD_W-1:0];
        2'd2:    pgs <= wdata[PGS_W-1:0];
        default: rls <= wdata[RLS_W-1:0];
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rval = DATA_W'(lat);
      2'd1:    rval = DATA_W'(pwd);
      2'd2:    rval = DATA_W'(pgs);
      default: rval = DATA_W'(rls);
    endcase
  end
endmodule

// File: rtl/dmacsr_launch.sv
module dmacsr_launch #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rlen_we,
  input  logic             wlen_we,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic             cmd_abort,
  input  logic             cmd_clear,
  input  logic             eng_done,
  input  logic             eng_error,
  output logic [LEN_W-1:0] rlen,
  output logic [LEN_W-1:0] wlen,
  output logic             dir,
  output logic             start,
  output logic             abort,
  output logic             busy,
  output logic             err,
  output logic             irq
);
  logic launch;
  assign launch = !busy && (rlen_we || wlen_we);

  always_ff @(posedge clk) begin
    if (rst) begin
      rlen  <= '0;
      wlen  <= '0;
      dir   <= 1'b0;
      start <= 1'b0;
      abort <= 1'b0;
      busy  <= 1'b0;
      err   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      start <= launch;
      abort <= cmd_abort;
      if (cmd_abort) begin
        busy <= 1'b0;
        err  <= 1'b0;
      end else begin
        if (eng_done)  busy <= 1'b0;
        if (eng_error) err  <= 1'b1;
      end
      if (launch) begin
        busy <= 1'b1;
        dir  <= wlen_we;
        if (wlen_we) wlen <= len_wdata;
        else         rlen <= len_wdata;
      end
      if (eng_done)       irq <= 1'b1;
      else if (cmd_clear) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dmacsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MEM_AW = 24,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_start,
  output logic              eng_dir,
  output logic [MEM_AW-1:0] eng_mem_addr,
  output logic [31:0]       eng_bus_addr,
  output logic [LEN_W-1:0]  eng_len,
  output logic              eng_abort,
  input  logic              eng_done,
  input  logic              eng_error,
  input  logic              eng_io_busy,
  output logic              irq,
  output logic [7:0]        d1_lat,
  output logic [7:0]        d1_pwd,
  output logic [3:0]        d1_pgs,
  output logic [1:0]        d1_rls,
  output logic [7:0]        d2_lat,
  output logic [7:0]        d2_pwd,
  output logic [3:0]        d2_pgs,
  output logic [1:0]        d2_rls
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              unused_addr_lsb;
  assign word = reg_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^reg_addr[1:0];

  // address registers
  logic [MEM_AW-1:0] mem_addr_q;
  logic [31:0]       bus_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr_q <= '0;
      bus_addr_q <= '0;
    end else if (reg_we) begin
      if (word == WORD_W'(WI_MEM)) mem_addr_q <= reg_wdata[MEM_AW-1:0];
      if (word == WORD_W'(WI_BUS)) bus_addr_q <= reg_wdata;
    end
  end

  // launch, status and interrupt
  logic             stat_wr;
  logic [LEN_W-1:0] rlen_q, wlen_q;
  logic             dma_busy, dma_err;

  assign stat_wr = reg_we && (word == WORD_W'(WI_STAT));

  dmacsr_launch #(.LEN_W(LEN_W)) u_launch (
    .clk       (clk),
    .rst       (rst),
    .rlen_we   (reg_we && (word == WORD_W'(WI_RLEN))),
    .wlen_we   (reg_we && (word == WORD_W'(WI_WLEN))),
    .len_wdata (reg_wdata[LEN_W-1:0]),
    .cmd_abort (stat_wr && reg_wdata[SC_ABORT]),
    .cmd_clear (stat_wr && reg_wdata[SC_CLEAR]),
    .eng_done  (eng_done),
    .eng_error (eng_error),
    .rlen      (rlen_q),
    .wlen      (wlen_q),
    .dir       (eng_dir),
    .start     (eng_start),
    .abort     (eng_abort),
    .busy      (dma_busy),
    .err       (dma_err),
    .irq       (irq)
  );

  // per-domain timing sets
  logic [LAT_W-1:0]  t_lat [NDOM];
  logic [PWD_W-1:0]  t_pwd [NDOM];
  logic [PGS_W-1:0]  t_pgs [NDOM];
  logic [RLS_W-1:0]  t_rls [NDOM];
  logic [DATA_W-1:0] t_rval[NDOM];
  logic [NDOM-1:0]   t_hit;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    localparam logic [WORD_W-1:0] BASE = WORD_W'(WI_TIM + TIM_STRIDE * d);
    logic [WORD_W-1:0] off;
    assign off      = word - BASE;
    assign t_hit[d] = (word >= BASE) && (off[WORD_W-1:2] == '0);

    dmacsr_timing_set u_set (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (reg_we && t_hit[d]),
      .wr_sel (off[1:0]),
      .rd_sel (off[1:0]),
      .wdata  (reg_wdata[TFLD_W-1:0]),
      .lat    (t_lat[d]),
      .pwd    (t_pwd[d]),
      .pgs    (t_pgs[d]),
      .rls    (t_rls[d]),
      .rval   (t_rval[d])
    );
  end

  // registered readback
  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (word)
      WORD_W'(WI_MEM):  rd_next = 32'(mem_addr_q);
      WORD_W'(WI_BUS):  rd_next = bus_addr_q;
      WORD_W'(WI_RLEN): rd_next = 32'(rlen_q);
      WORD_W'(WI_WLEN): rd_next = 32'(wlen_q);
      WORD_W'(WI_STAT): begin
        rd_next[SB_BUSY] = dma_busy;
        rd_next[SB_IO]   = eng_io_busy;
        rd_next[SB_ERR]  = dma_err;
        rd_next[SB_IRQ]  = irq;
      end
      default: begin
        for (int d = 0; d < NDOM; d++)
          if (t_hit[d]) rd_next = t_rval[d];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assign eng_mem_addr = mem_addr_q;
  assign eng_bus_addr = bus_addr_q;
  assign eng_len      = eng_dir ? wlen_q : rlen_q;

  assign d1_lat = t_lat[0];
  assign d1_pwd = t_pwd[0];
  assign d1_pgs = t_pgs[0];
  assign d1_rls = t_rls[0];
  assign d2_lat = t_lat[1];
  assign d2_pwd = t_pwd[1];
  assign d2_pgs = t_pgs[1];
  assign d2_rls = t_rls[1];
endmodule

// File: rtl/dma_csr_bank_checker.sv
module dma_csr_bank_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [1:0]        cmd_bits,
  input logic [31:0]       reg_rdata,
  input logic              eng_start,
  input logic              eng_abort,
  input logic              eng_done,
  input logic              irq,
  input logic              dma_busy
);
  localparam int WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;
  logic              unused_chk_lsb;
  assign word = reg_addr[ADDR_W-1:2];
  assign unused_chk_lsb = ^reg_addr[1:0];

  logic len_wr, clr_wr, abort_wr;
  assign len_wr   = reg_we && (word == WORD_W'(2) || word == WORD_W'(3));
  assign clr_wr   = reg_we && (word == WORD_W'(4)) && cmd_bits[1];
  assign abort_wr = reg_we && (word == WORD_W'(4)) && cmd_bits[0];

  a_r4_start_single_cycle: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  a_r5_busy_blocks_launch: assert property (@(posedge clk) disable iff (rst)
    (len_wr && dma_busy) |=> !eng_start);

  a_r6_done_sets_irq: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> irq);

  a_r7_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_wr) |=> irq);

  a_r8_abort_pulse: assert property (@(posedge clk) disable iff (rst)
    abort_wr |=> (eng_abort && !dma_busy));

  a_r2_mem_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (word == WORD_W'(0)) |=> (reg_rdata[31:24] == 8'h00));
endmodule

bind dma_csr_bank dma_csr_bank_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .cmd_bits  (reg_wdata[1:0]),
  .reg_rdata (reg_rdata),
  .eng_start (eng_start),
  .eng_abort (eng_abort),
  .eng_done  (eng_done),
  .irq       (irq),
  .dma_busy  (dma_busy)
);

// File: tb/dma_csr_bank_tb.sv
module dma_csr_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_start, eng_dir, eng_abort, irq;
  logic [23:0] eng_mem_addr, eng_len;
  logic [31:0] eng_bus_addr;
  logic        eng_done = 1'b0, eng_error = 1'b0, eng_io_busy = 1'b0;
  logic [7:0]  d1_lat, d1_pwd, d2_lat, d2_pwd;
  logic [3:0]  d1_pgs, d2_pgs;
  logic [1:0]  d1_rls, d2_rls;

  int checks = 0;
  int errors = 0;

  // bench model of the plain registers
  logic [31:0] m_mem, m_bus, m_rlen, m_wlen;
  logic [31:0] m_tim [8];

  always #10 clk = ~clk;

  dma_csr_bank u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mask_tim(input int idx, input logic [31:0] d);
    case (idx % 4)
      0, 1:    return {24'h0, d[7:0]};
      2:       return {28'h0, d[3:0]};
      default: return {30'h0, d[1:0]};
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input int w);
    if (w == 0) return m_mem;
    if (w == 1) return m_bus;
    if (w == 2) return m_rlen;
    if (w == 3) return m_wlen;
    if (w >= 5 && w <= 12) return m_tim[w-5];
    return 32'h0;
  endfunction

  function automatic void model_wr(input int w, input logic [31:0] d);
    if (w == 0) m_mem = {8'h0, d[23:0]};
    else if (w == 1) m_bus = d;
    else if (w >= 5 && w <= 12) m_tim[w-5] = mask_tim(w-5, d);
  endfunction

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    m_mem = 0; m_bus = 0; m_rlen = 0; m_wlen = 0;
    for (int i = 0; i < 8; i++) m_tim[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 start", {31'h0, eng_start}, 0);
    check("R1 abort", {31'h0, eng_abort}, 0);
    check("R1 irq", {31'h0, irq}, 0);
    rd(8'h10, v); check("R1 status", v, 0);
    rd(8'h00, v); check("R1 mem addr", v, 0);
    rd(8'h30, v); check("R1 d2 release", v, 0);

    // R2 R3 R10 random register traffic
    for (int i = 0; i < 300; i++) begin
      int w;
      logic [31:0] d;
      w = $urandom_range(0, 15);
      if (w >= 2 && w <= 4) w = w + 3;
      d = $urandom;
      wr(8'((w << 2) | $urandom_range(0, 3)), d);
      model_wr(w, d);
      w = $urandom_range(0, 63);
      if (w >= 2 && w <= 4) w = 0;
      rd(8'((w << 2) | $urandom_range(0, 3)), v);
      check(w < 2 ? "R2 addr readback" : (w <= 12 ? "R10 timing readback" : "R3 undecoded zero"),
            v, exp_read(w));
    end
    check("R2 mem port", {8'h0, eng_mem_addr}, m_mem);
    check("R2 bus port", eng_bus_addr, m_bus);
    check("R10 d1 ports", {8'h0, d1_lat, d1_pwd, 4'h0, d1_pgs, 6'h0, d1_rls},
          {8'h0, m_tim[0][7:0], m_tim[1][7:0], m_tim[2][7:0], m_tim[3][7:0]});
    check("R10 d2 ports", {8'h0, d2_lat, d2_pwd, 4'h0, d2_pgs, 6'h0, d2_rls},
          {8'h0, m_tim[4][7:0], m_tim[5][7:0], m_tim[6][7:0], m_tim[7][7:0]});

    // R4 launch local-to-bus
    wr(8'h08, 32'hFFAB_CDEF); m_rlen = 32'h00AB_CDEF;
    check("R4 start pulse", {31'h0, eng_start}, 1);
    check("R4 dir", {31'h0, eng_dir}, 0);
    check("R4 len", {8'h0, eng_len}, m_rlen);
    rd(8'h10, v);
    check("R4 start single", {31'h0, eng_start}, 0);
    check("R4 busy bit", v, 32'h1);
    rd(8'h08, v); check("R4 len readback", v, m_rlen);

    // R5 length write while busy ignored
    wr(8'h0C, 32'h0000_0055);
    check("R5 no start", {31'h0, eng_start}, 0);
    check("R5 eng_len kept", {8'h0, eng_len}, m_rlen);
    rd(8'h0C, v); check("R5 wlen kept", v, m_wlen);

    // R6 done ends transfer and raises interrupt
    eng_done = 1'b1; @(posedge clk); @(negedge clk); eng_done = 1'b0;
    check("R6 irq pin", {31'h0, irq}, 1);
    rd(8'h10, v); check("R6 status after done", v, 32'h8);

    // R4 launch bus-to-local
    wr(8'h0C, 32'h0000_0010); m_wlen = 32'h10;
    check("R4 dir bus-to-local", {31'h0, eng_dir}, 1);
    check("R4 len bus-to-local", {8'h0, eng_len}, 32'h10);

    // R7 clear behaviour
    wr(8'h10, 32'h0); check("R7 no clear", {31'h0, irq}, 1);
    wr(8'h10, 32'h2); check("R7 clear", {31'h0, irq}, 0);

    // R9 error and io busy
    eng_error = 1'b1; @(posedge clk); @(negedge clk); eng_error = 1'b0;
    rd(8'h10, v); check("R9 error sticky", v, 32'h5);
    eng_io_busy = 1'b1;
    rd(8'h10, v); check("R9 io busy", v, 32'h7);
    eng_io_busy = 1'b0;

    // R8 abort
    wr(8'h10, 32'h1);
    check("R8 abort pulse", {31'h0, eng_abort}, 1);
    rd(8'h10, v);
    check("R8 abort single", {31'h0, eng_abort}, 0);
    check("R8 status cleared", v, 32'h0);

    // R6 done and clear in same cycle
    eng_done = 1'b1;
    wr(8'h10, 32'h2);
    eng_done = 1'b0;
    check("R6 done beats clear", {31'h0, irq}, 1);
    wr(8'h10, 32'h2);
    check("R7 clear after tie", {31'h0, irq}, 0);

    // R3 write to undecoded offset changes nothing
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, v); check("R3 undecoded write", v, 0);
    rd(8'h04, v); check("R3 bus addr intact", v, m_bus);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule